// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupts

This block is a register-mapped general-purpose I/O controller for up to 32 pins. Software sets each pin as an input or as an output driven from a value register, and can read back the state of every pin. Each input pin is first retimed through a two-flop synchronizer.

Every pin also has its own interrupt detector. A mode bit picks level or edge sensitivity, and a polarity bit picks which level or which edge counts. Detected events latch into a status register whether or not the pin is enabled. The pending view is that status masked by the enable register. A single interrupt line goes high while any pending bit is set. Software clears events by writing ones to a clear register, normally the value it just read from the pending register. A new event on a pin wins over a clear of that pin in the same cycle.

The bus is a plain strobed interface with word-aligned byte addresses. Writes take effect at the clock edge that samples the strobe. Read data is registered and appears one cycle after the read strobe.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: The pin count NPINS (at most 32) is a parameter, with one bit per pin in every register; read data bits at NPINS and above are always 0.
- R2: Registers sit at byte offsets 0x00 direction, 0x04 value, 0x08 interrupt enable, 0x0c status, 0x10 pending, 0x14 clear, 0x18 mode, 0x1c polarity; enable, mode and polarity read back what was written, and the clear register reads as 0.
- R3: A direction bit of 1 makes the pin an input (pin_oe low); 0 makes it an output with pin_oe high and pin_out equal to the value register bit. Direction resets to all inputs.
- R4: Reading the value register returns, per pin, the synchronized input for input pins and the driven value for output pins.
- R5: With mode bit 0 (level), polarity 1 means active-high and 0 means active-low; an event is raised on every cycle the synchronized pin is at its active level.
- R6: With mode bit 1 (edge), polarity 1 selects falling edges and 0 selects rising edges; only a change of the synchronized pin in the selected direction raises an event.
- R7: Writing 1 to a clear register bit clears that pin's status bit; bits written as 0 leave their status unchanged.
- R8: The status register latches events of all pins regardless of enable; the pending register reads status AND enable.
- R9: Interrupt enable resets to all zeros and the interrupt output is low after reset.
- R10: The interrupt output is registered and equals the OR of (status AND enable) one cycle earlier.
- R11: If a clear and a new event hit the same pin in the same cycle, the status bit stays set.
- R12: A pin change presented before clock edge 1 is latched into status at edge 3 and raises the interrupt at edge 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data, valid the cycle after bus_rd |
| pin_in | input | NPINS | Pin input levels, asynchronous |
| pin_out | output | NPINS | Output values for pins set as outputs |
| pin_oe | output | NPINS | Output enable per pin, high for outputs |
| irq | output | 1 | Combined interrupt |

## Verification
A pin change goes through two synchronizer flops and the status latch, so it shows in status three edges after it is driven. The interrupt follows one edge later. A read returns its data one edge after the strobe, and a write or clear acts at the edge that samples it. Inputs are driven on falling edges. The latency check counts falling edges exactly: the interrupt is low after three and high after four. Other checks wait at least five cycles after a pin change before reading, so each result has settled past its due cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  // Word index decoded from byte address bits [4:2]
  typedef enum logic [2:0] {
    RS_DIR  = 3'd0,
    RS_VAL  = 3'd1,
    RS_IEN  = 3'd2,
    RS_STAT = 3'd3,
    RS_PEND = 3'd4,
    RS_CLR  = 3'd5,
    RS_MODE = 3'd6,
    RS_POL  = 3'd7
  } reg_sel_e;

  localparam int unsigned SEL_LSB = 2;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned MAP_W   = SEL_LSB + SEL_W;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] mode,
  input  logic [W-1:0] pol,
  output logic [W-1:0] evt
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic lvl_hit, rise, fall;
    always_comb begin
      lvl_hit = pol[i] ? lvl[i] : ~lvl[i];
      rise    = ~prev_q[i] &  lvl[i];
      fall    =  prev_q[i] & ~lvl[i];
      if (mode[i]) evt[i] = pol[i] ? fall : rise;
      else         evt[i] = lvl_hit;
    end
  end
endmodule

// File: rtl/gpio_pend.sv
module gpio_pend #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] clr_vec,
  input  logic [W-1:0] en,
  output logic [W-1:0] raw_q,
  output logic         irq_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= '0;
      irq_q <= 1'b0;
    end else begin
      // set wins over clear
      raw_q <= (raw_q & ~clr_vec) | evt;
      irq_q <= |(raw_q & en);
    end
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_state,
  input  logic [NPINS-1:0]  raw_q,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  out_q,
  output logic [NPINS-1:0]  en_q,
  output logic [NPINS-1:0]  mode_q,
  output logic [NPINS-1:0]  pol_q,
  output logic [NPINS-1:0]  clr_vec
);
  logic             hit;
  reg_sel_e         sel;
  logic [NPINS-1:0] wd;
  logic [NPINS-1:0] rd_mux;

  assign hit = (bus_addr[SEL_LSB-1:0] == '0) && ((bus_addr >> MAP_W) == '0);
  assign sel = reg_sel_e'(bus_addr[SEL_LSB +: SEL_W]);
  assign wd  = bus_wdata[NPINS-1:0];

  assign clr_vec = (bus_wr && hit && sel == RS_CLR) ? wd : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '1;
      out_q  <= '0;
      en_q   <= '0;
      mode_q <= '0;
      pol_q  <= '0;
    end else if (bus_wr && hit) begin
      case (sel)
        RS_DIR:  dir_q  <= wd;
        RS_VAL:  out_q  <= wd;
        RS_IEN:  en_q   <= wd;
        RS_MODE: mode_q <= wd;
        RS_POL:  pol_q  <= wd;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      case (sel)
        RS_DIR:  rd_mux = dir_q;
        RS_VAL:  rd_mux = pin_state;
        RS_IEN:  rd_mux = en_q;
        RS_STAT: rd_mux = raw_q;
        RS_PEND: rd_mux = raw_q & en_q;
        RS_MODE: rd_mux = mode_q;
        RS_POL:  rd_mux = pol_q;
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= DATA_W'(rd_mux);
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int unsigned NPINS       = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  logic [NPINS-1:0] sync_lvl;
  logic [NPINS-1:0] evt;
  logic [NPINS-1:0] raw_q;
  logic [NPINS-1:0] dir_q, out_q, en_q, mode_q, pol_q;
  logic [NPINS-1:0] clr_vec;
  logic [NPINS-1:0] pin_state;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(sync_lvl)
  );

  gpio_evt_detect #(.W(NPINS)) u_det (
    .clk(clk), .rst(rst), .lvl(sync_lvl), .mode(mode_q), .pol(pol_q), .evt(evt)
  );

  gpio_pend #(.W(NPINS)) u_pend (
    .clk(clk), .rst(rst), .evt(evt), .clr_vec(clr_vec), .en(en_q),
    .raw_q(raw_q), .irq_q(irq)
  );

  assign pin_state = (dir_q & sync_lvl) | (~dir_q & out_q);

  gpio_regs #(.NPINS(NPINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_state(pin_state), .raw_q(raw_q),
    .dir_q(dir_q), .out_q(out_q), .en_q(en_q),
    .mode_q(mode_q), .pol_q(pol_q), .clr_vec(clr_vec)
  );

  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic [NPINS-1:0]  evt,
  input logic [NPINS-1:0]  raw_q,
  input logic [NPINS-1:0]  en_q,
  input logic [NPINS-1:0]  clr_vec
);
  // R11: every detected event is latched, even under a clear
  assert_event_latched_R11: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((raw_q & $past(evt)) == $past(evt)));

  // R6: no status bit rises without an event
  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((raw_q & ~$past(raw_q) & ~$past(evt)) == '0));

  // R7: cleared bits drop unless re-set by an event
  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (!rst && (clr_vec != '0)) |=> ((raw_q & $past(clr_vec) & ~$past(evt)) == '0));

  // R10: interrupt is OR of enabled status one cycle earlier
  assert_irq_follows_R10: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (irq == (|($past(raw_q & en_q)))));

  // R9: enable cleared and interrupt low right after reset
  assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> ((en_q == '0) && !irq));

  if (NPINS < DATA_W) begin : g_upper
    // R1: unused read data bits stay zero
    assert_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
      ((bus_rdata >> NPINS) == '0));
  end
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_rdata(bus_rdata), .irq(irq),
  .evt(evt), .raw_q(raw_q), .en_q(en_q), .clr_vec(clr_vec)
);

// File: tb/gpio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_bench;
  localparam int unsigned NP = 12;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 5;
  localparam logic [DW-1:0] ALL = 32'h0000_0FFF;

  localparam logic [AW-1:0] A_DIR = 5'h00, A_VAL = 5'h04, A_IEN = 5'h08,
    A_STAT = 5'h0c, A_PEND = 5'h10, A_CLR = 5'h14, A_MODE = 5'h18, A_POL = 5'h1c;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_ctrl #(.NPINS(NP), .DATA_W(DW), .ADDR_W(AW)) u_gpio_irq_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    chk("R9 irq after reset", {31'd0, irq}, 32'd0);
    rd(A_DIR, d); chk("R3 direction reset", d, ALL);
    rd(A_IEN, d); chk("R9 enable reset", d, 32'd0);
    rd(A_VAL, d); chk("R4 inputs low", d, 32'd0);
    chk("R3 oe reset", {20'd0, pin_oe}, 32'd0);
  endtask

  task automatic t_regmap();
    logic [DW-1:0] d;
    wr(A_IEN, 32'hFFFF_F5A5);
    wr(A_MODE, 32'h0000_03C3);
    wr(A_POL, 32'h0000_00F0);
    rd(A_IEN, d);  chk("R2 enable at 0x08 (R1 masked)", d, 32'h0000_05A5);
    rd(A_MODE, d); chk("R2 mode at 0x18", d, 32'h0000_03C3);
    rd(A_POL, d);  chk("R2 polarity at 0x1c", d, 32'h0000_00F0);
    rd(A_CLR, d);  chk("R2 clear reads zero", d, 32'd0);
    wr(A_IEN, 32'd0);
    wr(A_MODE, 32'd0);
    wr(A_POL, 32'd0);
  endtask

  task automatic t_dir();
    logic [DW-1:0] d;
    wr(A_DIR, 32'h0000_00F0);
    wr(A_VAL, 32'hFFFF_FFFF);
    chk("R3 oe from direction", {20'd0, pin_oe}, 32'h0000_0F0F);
    chk("R3 pin_out from value", {20'd0, pin_out}, ALL);
    rd(A_VAL, d); chk("R4 mixed read (R1 upper zero)", d, 32'h0000_0F0F);
    pin_in[5] = 1'b1;
    settle();
    rd(A_VAL, d); chk("R4 input sampled", d, 32'h0000_0F2F);
    pin_in[5] = 1'b0;
    wr(A_DIR, ALL);
    wr(A_VAL, 32'd0);
  endtask

  task automatic t_level();
    logic [DW-1:0] d;
    wr(A_POL, ALL);
    settle();
    wr(A_CLR, ALL);
    rd(A_STAT, d); chk("R7 clear all", d, 32'd0);
    pin_in[0] = 1'b1;
    settle();
    rd(A_STAT, d); chk("R5 active-high level", d, 32'h1);
    rd(A_PEND, d); chk("R8 pending masked by enable", d, 32'h0);
    chk("R8 no irq when disabled", {31'd0, irq}, 32'd0);
    wr(A_IEN, 32'h1);
    @(negedge clk);
    rd(A_PEND, d); chk("R8 pending when enabled", d, 32'h1);
    chk("R10 irq raised", {31'd0, irq}, 32'd1);
    wr(A_CLR, 32'h1);
    rd(A_STAT, d); chk("R5 level re-asserts", d, 32'h1);
    pin_in[0] = 1'b0;
    settle();
    wr(A_CLR, 32'h1);
    repeat (2) @(negedge clk);
    rd(A_STAT, d); chk("R5 inactive level clears", d, 32'h0);
    chk("R10 irq dropped", {31'd0, irq}, 32'd0);
    wr(A_IEN, 32'd0);
    wr(A_POL, 32'h0000_0FFE);
    settle();
    rd(A_STAT, d); chk("R5 active-low level", d, 32'h1);
    wr(A_POL, ALL);
    wr(A_CLR, ALL);
  endtask

  task automatic t_edge();
    logic [DW-1:0] d;
    wr(A_MODE, ALL);
    wr(A_POL, 32'h0000_0002);
    wr(A_CLR, ALL);
    rd(A_STAT, d); chk("R6 quiet in edge mode", d, 32'h0);
    pin_in[2] = 1'b1; settle();
    rd(A_STAT, d); chk("R6 rising edge", d, 32'h4);
    pin_in[1] = 1'b1; settle();
    rd(A_STAT, d); chk("R6 rise ignored when falling selected", d, 32'h4);
    pin_in[1] = 1'b0; settle();
    rd(A_STAT, d); chk("R6 falling edge", d, 32'h6);
    pin_in[2] = 1'b0; settle();
    rd(A_STAT, d); chk("R6 fall ignored when rising selected", d, 32'h6);
    wr(A_CLR, 32'h2);
    rd(A_STAT, d); chk("R7 zero bits untouched", d, 32'h4);
    wr(A_CLR, 32'h4);
    settle();
    rd(A_STAT, d); chk("R6 edge does not persist", d, 32'h0);
  endtask

  task automatic t_latency();
    logic [DW-1:0] d;
    wr(A_IEN, 32'h8);
    @(negedge clk);
    pin_in[3] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 irq low after three edges", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R12 irq high at fourth edge", {31'd0, irq}, 32'd1);
    rd(A_PEND, d);
    wr(A_CLR, d);
    @(negedge clk);
    chk("R10 irq low after ack", {31'd0, irq}, 32'd0);
    pin_in[3] = 1'b0;
    wr(A_IEN, 32'd0);
    settle();
  endtask

  task automatic t_collide();
    logic [DW-1:0] d;
    wr(A_MODE, 32'h0000_0FEF);
    wr(A_POL, 32'h0000_0012);
    wr(A_CLR, ALL);
    pin_in[4] = 1'b1; settle();
    wr(A_CLR, 32'h10);
    rd(A_STAT, d); chk("R11 event wins over clear", d, 32'h10);
    pin_in[4] = 1'b0; settle();
    wr(A_CLR, 32'h10);
    rd(A_STAT, d); chk("R7 cleared once inactive", d, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_dir();
    t_level();
    t_edge();
    t_latency();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule